// File: doc/BRIEF.md
# Restartable multi-register transfer sequencer

This block moves a group of registers to or from memory, one word per set bit of a register-select mask. A start command latches the mask, a base address and a direction. The block then walks the mask from bit 0 upward. For each set bit it issues one word access on a simple request/acknowledge bus. Each access targets the base address plus two bytes per transfer already completed.

A bus error stops the sequence and parks the block in a faulted state. Transfers that had already completed are left as they are. In the faulted state the block exposes a saved-state record that software can read and rewrite. The record holds the latched base address, the number of completed transfers, the direction and a move-in-progress flag.

A resume command then does one of two things, chosen by that flag:
- **Flag set (continue):** the block keeps the saved base. It rescans the mask from bit 0 and skips as many set bits as the saved count. It then repeats the faulted transfer and carries on.
- **Flag cleared (restart):** the block discards the progress. It takes the base address input again and redoes every transfer from the first set bit.

Top module: `mreg_xfer_seq`

## Requirements
- R1: Each set mask bit produces exactly one bus access, in ascending bit order, with `rf_sel` equal to that bit index during the access; clear bits produce none.
- R2: The n-th completed transfer of a sequence (n counted from 0) uses `bus_addr = base + 2*n`. A request is held with a stable address until `bus_ack` or `bus_err`.
- R3: The direction is chosen at start. With `dir = 0` (register to memory), `bus_we = 1` and `bus_wdata = rf_rdata`. With `dir = 1` (memory to register), `bus_we = 0`, and on acknowledge `rf_we = 1` with `rf_wdata = bus_rdata`.
- R4: `done` is a single-cycle pulse after the last set bit completes. A start with an all-zero mask gives `done` with no bus request.
- R5: A `bus_err` during an access gives a one-cycle `fault` pulse and holds `faulted` high. The record then shows: `sv_count` = transfers completed before the fault, `sv_base` = latched base, `sv_dir` = direction, `sv_mv = 1`. No bus request is issued while faulted, and completed transfers are not undone.
- R6: `resume` with `sv_mv = 1` keeps `sv_base` and ignores `base_addr`. It skips the first `sv_count` set mask bits, repeats the faulted transfer at its original address, then finishes the remaining bits.
- R7: `resume` with `sv_mv = 0` reloads the base from `base_addr` and clears the count. It re-executes every set bit from the lowest one, accessing earlier locations again.
- R8: `sv_wr` overwrites all four record fields only while `faulted` is high. Outside the faulted state it is ignored, and the record stays unchanged until the next start.
- R9: When `bus_err` and `bus_ack` are high in the same cycle, the error wins. The access counts as a fault and no register write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (ignored unless idle) |
| dir | input | 1 | 0 = register to memory, 1 = memory to register |
| mask | input | MASK_W | Register-select mask |
| base_addr | input | ADDR_W | Base address, taken at start and at restart |
| resume | input | 1 | Leave the faulted state |
| sv_wr | input | 1 | Write the saved-state record |
| sv_wr_base | input | ADDR_W | Base address to write |
| sv_wr_count | input | CNT_W | Completed-transfer count to write |
| sv_wr_dir | input | 1 | Direction to write |
| sv_wr_mv | input | 1 | Move-in-progress flag to write |
| sv_base | output | ADDR_W | Record: latched base address |
| sv_count | output | CNT_W | Record: completed transfers |
| sv_dir | output | 1 | Record: direction |
| sv_mv | output | 1 | Record: move-in-progress flag |
| rf_sel | output | IDX_W | Register index of the current transfer |
| rf_rdata | input | DATA_W | Selected register value |
| rf_we | output | 1 | Register write strobe |
| rf_wdata | output | DATA_W | Register write data |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read data |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| busy | output | 1 | Sequence running or faulted |
| faulted | output | 1 | Waiting in the faulted state |
| done | output | 1 | Sequence complete pulse |
| fault | output | 1 | Bus error pulse |

## Verification
The bench builds the block with its defaults: MASK_W = 16, ADDR_W = 24 and DATA_W = 16. The full 16-bit mask therefore puts both bit 0 and bit 15 within reach, together with sparse masks that need long scan gaps. With a 5-bit count, a rewritten `sv_count` can steer the continue-style rescan to skip an arbitrary number of set bits. This exposes the difference between counting set bits and storing a bit pointer. A bus model that raises acknowledge and error together on the injected access reaches the error-priority corner in the load direction.

// File: rtl/mreg_xfer_seq.sv
module mreg_xfer_seq #(
  parameter int MASK_W = 16,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int IDX_W  = $clog2(MASK_W),
  parameter int CNT_W  = $clog2(MASK_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [MASK_W-1:0] mask,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              resume,
  input  logic              sv_wr,
  input  logic [ADDR_W-1:0] sv_wr_base,
  input  logic [CNT_W-1:0]  sv_wr_count,
  input  logic              sv_wr_dir,
  input  logic              sv_wr_mv,
  output logic [ADDR_W-1:0] sv_base,
  output logic [CNT_W-1:0]  sv_count,
  output logic              sv_dir,
  output logic              sv_mv,
  output logic [IDX_W-1:0]  rf_sel,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  output logic              busy,
  output logic              faulted,
  output logic              done,
  output logic              fault
);

  typedef enum logic [1:0] {IDLE, SCAN, XFER, PARK} state_t;

  state_t            st;
  logic [MASK_W-1:0] mask_q;
  logic [ADDR_W-1:0] base_q;
  logic              dir_q, mv_q, done_q, fault_q;
  logic [CNT_W-1:0]  cnt_q, seen_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [MASK_W-1:0] hi;
  logic              rest_empty, hit;

  assign hi         = mask_q >> ptr_q;
  assign rest_empty = (hi >> 1) == '0;
  assign hit        = mask_q[ptr_q];

  assign bus_req   = st == XFER;
  assign bus_we    = ~dir_q;
  assign bus_addr  = base_q + ADDR_W'({cnt_q, 1'b0});
  assign bus_wdata = rf_rdata;
  assign rf_sel    = ptr_q;
  assign rf_we     = bus_req && bus_ack && !bus_err && dir_q;
  assign rf_wdata  = bus_rdata;

  assign busy    = st != IDLE;
  assign faulted = st == PARK;
  assign done    = done_q;
  assign fault   = fault_q;
  assign sv_base  = base_q;
  assign sv_count = cnt_q;
  assign sv_dir   = dir_q;
  assign sv_mv    = mv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      mask_q  <= '0;
      base_q  <= '0;
      dir_q   <= 1'b0;
      mv_q    <= 1'b0;
      cnt_q   <= '0;
      seen_q  <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          mask_q <= mask;
          base_q <= base_addr;
          dir_q  <= dir;
          mv_q   <= 1'b0;
          cnt_q  <= '0;
          seen_q <= '0;
          ptr_q  <= '0;
          if (mask == '0) done_q <= 1'b1;
          else            st     <= SCAN;
        end
        SCAN: begin
          if (hit && seen_q == cnt_q) begin
            st <= XFER;
          end else if (rest_empty) begin
            st     <= IDLE;
            mv_q   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ptr_q <= ptr_q + 1'b1;
            if (hit) seen_q <= seen_q + 1'b1;
          end
        end
        XFER: begin
          if (bus_err) begin
            st      <= PARK;
            mv_q    <= 1'b1;
            fault_q <= 1'b1;
          end else if (bus_ack) begin
            cnt_q  <= cnt_q + 1'b1;
            seen_q <= seen_q + 1'b1;
            if (rest_empty) begin
              st     <= IDLE;
              mv_q   <= 1'b0;
              done_q <= 1'b1;
            end else begin
              ptr_q <= ptr_q + 1'b1;
              st    <= SCAN;
            end
          end
        end
        PARK: begin
          if (resume) begin
            mask_q <= mask;
            ptr_q  <= '0;
            seen_q <= '0;
            if (!mv_q) begin
              cnt_q  <= '0;
              base_q <= base_addr;
            end
            if (mask == '0) begin
              st     <= IDLE;
              mv_q   <= 1'b0;
              done_q <= 1'b1;
            end else begin
              st <= SCAN;
            end
          end else if (sv_wr) begin
            base_q <= sv_wr_base;
            cnt_q  <= sv_wr_count;
            dir_q  <= sv_wr_dir;
            mv_q   <= sv_wr_mv;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mreg_xfer_seq_chk.sv
module mreg_xfer_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              faulted,
  input logic              done,
  input logic              fault,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              bus_err,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rf_we,
  input logic              sv_mv,
  input logic [CNT_W-1:0]  sv_count,
  input logic [ADDR_W-1:0] sv_base
);

  assert_hold_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !bus_err |=> bus_req && $stable(bus_addr));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  assert_fault_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> faulted && sv_mv);

  assert_quiet_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    faulted |-> !bus_req);

  assert_record_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(sv_count) && $stable(sv_base));

  assert_err_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !rf_we);

endmodule

bind mreg_xfer_seq mreg_xfer_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/mreg_xfer_seq_tb.sv
`timescale 1ns/100ps
module mreg_xfer_seq_tb;
  localparam int MASK_W = 16, ADDR_W = 24, DATA_W = 16;
  localparam int IDX_W = $clog2(MASK_W), CNT_W = $clog2(MASK_W + 1);

  logic clk = 0, rst_n = 0;
  logic start = 0, dir = 0, resume = 0, sv_wr = 0, sv_wr_dir = 0, sv_wr_mv = 0;
  logic [MASK_W-1:0] mask = '0;
  logic [ADDR_W-1:0] base_addr = '0, sv_wr_base = '0;
  logic [CNT_W-1:0]  sv_wr_count = '0;
  logic [ADDR_W-1:0] sv_base, bus_addr;
  logic [CNT_W-1:0]  sv_count;
  logic sv_dir, sv_mv, rf_we, bus_req, bus_we, busy, faulted, done, fault;
  logic [IDX_W-1:0]  rf_sel;
  logic [DATA_W-1:0] rf_rdata, rf_wdata, bus_wdata, bus_rdata;
  logic bus_ack, bus_err, inject;

  logic [15:0] mem [256];
  logic [15:0] rf  [16];
  logic [ADDR_W-1:0] log_addr [64];
  logic [IDX_W-1:0]  log_sel  [64];
  logic              log_we   [64];
  int txn_no;
  int err_idx = -1;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mreg_xfer_seq u_dut (.*);

  assign inject    = bus_req && (txn_no == err_idx);
  assign bus_ack   = bus_req;
  assign bus_err   = inject;
  assign bus_rdata = mem[bus_addr[8:1]];
  assign rf_rdata  = rf[rf_sel];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_no <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 16'h5000 + 16'(i);
      for (int i = 0; i < 16; i++)  rf[i]  <= 16'hA000 + 16'(i);
    end else begin
      if (bus_req) begin
        log_addr[txn_no & 63] <= bus_addr;
        log_sel[txn_no & 63]  <= rf_sel;
        log_we[txn_no & 63]   <= bus_we;
        txn_no <= txn_no + 1;
        if (bus_we && !inject) mem[bus_addr[8:1]] <= bus_wdata;
      end
      if (rf_we) rf[rf_sel] <= rf_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_end(output bit got_done, output bit got_fault);
    got_done = 0; got_fault = 0;
    for (int c = 0; c < 500 && !got_done && !got_fault; c++) begin
      @(negedge clk);
      got_done = done; got_fault = fault;
    end
  endtask

  task automatic kick(input logic d, input logic [15:0] m, input logic [23:0] b);
    @(negedge clk);
    dir = d; mask = m; base_addr = b; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic pulse_resume();
    resume = 1;
    @(negedge clk);
    resume = 0;
  endtask

  task automatic t_reset();
    chk("R4 reset done", done, 0);
    chk("R5 reset faulted", faulted, 0);
    chk("R1 reset bus_req", bus_req, 0);
  endtask

  task automatic t_store();
    bit d, f; int t0; int sels[4];
    sels = '{0, 5, 10, 15};
    t0 = txn_no;
    kick(0, 16'h8421, 24'h10);
    wait_end(d, f);
    chk("R4 store done", d, 1);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
    chk("R1 store count", txn_no - t0, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R1 sel order", log_sel[t0 + i], sels[i]);
      chk("R2 address step", log_addr[t0 + i], 24'h10 + 24'(2 * i));
      chk("R3 store we", log_we[t0 + i], 1);
      chk("R3 store data", mem[8 + i], 16'hA000 + 16'(sels[i]));
    end
  endtask

  task automatic t_empty();
    bit d, f; int t0;
    t0 = txn_no;
    kick(0, 16'h0000, 24'h30);
    d = done;
    chk("R4 empty done", d, 1);
    chk("R4 empty no bus", txn_no - t0, 0);
  endtask

  task automatic t_continue();
    bit d, f; int t0;
    t0 = txn_no;
    err_idx = t0 + 2;
    kick(0, 16'h00F0, 24'h60);
    wait_end(d, f);
    err_idx = -1;
    chk("R5 fault pulse", f, 1);
    @(negedge clk);
    chk("R5 fault one cycle", fault, 0);
    chk("R5 faulted", faulted, 1);
    chk("R5 count", sv_count, 2);
    chk("R5 base", sv_base, 24'h60);
    chk("R5 dir", sv_dir, 0);
    chk("R5 mv", sv_mv, 1);
    chk("R5 kept mem0", mem[8'h30], 16'hA004);
    chk("R5 kept mem1", mem[8'h31], 16'hA005);
    chk("R5 faulted untouched", mem[8'h32], 16'h5032);
    repeat (3) @(negedge clk);
    chk("R5 no req parked", txn_no - t0, 3);
    base_addr = 24'h80;
    pulse_resume();
    wait_end(d, f);
    chk("R6 done", d, 1);
    chk("R6 txn count", txn_no - t0, 5);
    chk("R6 repeat sel", log_sel[t0 + 3], 6);
    chk("R6 repeat addr", log_addr[t0 + 3], 24'h64);
    chk("R6 last addr", log_addr[t0 + 4], 24'h66);
    chk("R6 mem", mem[8'h33], 16'hA007);
  endtask

  task automatic t_restart();
    bit d, f; int t0;
    t0 = txn_no;
    err_idx = t0 + 1;
    kick(0, 16'h0003, 24'h90);
    wait_end(d, f);
    err_idx = -1;
    chk("R5 restart fault", f, 1);
    sv_wr = 1; sv_wr_base = 24'h90; sv_wr_count = 1; sv_wr_dir = 0; sv_wr_mv = 0;
    @(negedge clk);
    sv_wr = 0;
    chk("R8 mv written", sv_mv, 0);
    base_addr = 24'hA0;
    pulse_resume();
    wait_end(d, f);
    chk("R7 done", d, 1);
    chk("R7 txn count", txn_no - t0, 4);
    chk("R7 first sel", log_sel[t0 + 2], 0);
    chk("R7 new base", log_addr[t0 + 2], 24'hA0);
    chk("R7 second addr", log_addr[t0 + 3], 24'hA2);
    chk("R7 mem", mem[8'h51], 16'hA001);
  endtask

  task automatic t_edit_count();
    bit d, f; int t0;
    t0 = txn_no;
    err_idx = t0;
    kick(0, 16'h000F, 24'hC0);
    wait_end(d, f);
    err_idx = -1;
    chk("R5 count zero", sv_count, 0);
    sv_wr = 1; sv_wr_base = 24'hC0; sv_wr_count = 1; sv_wr_dir = 0; sv_wr_mv = 1;
    @(negedge clk);
    sv_wr = 0;
    chk("R8 count written", sv_count, 1);
    pulse_resume();
    wait_end(d, f);
    chk("R6 skip txn count", txn_no - t0, 4);
    chk("R6 skip sel", log_sel[t0 + 1], 1);
    chk("R6 skip addr", log_addr[t0 + 1], 24'hC2);
    chk("R6 skip tail", log_addr[t0 + 3], 24'hC6);
  endtask

  task automatic t_load();
    bit d, f; int t0;
    t0 = txn_no;
    kick(1, 16'h0006, 24'h40);
    wait_end(d, f);
    @(negedge clk);
    chk("R3 load done", d, 1);
    chk("R3 load we", log_we[t0], 0);
    chk("R3 rf1", rf[1], 16'h5020);
    chk("R3 rf2", rf[2], 16'h5021);
  endtask

  task automatic t_err_wins();
    bit d, f;
    err_idx = txn_no;
    kick(1, 16'h0001, 24'hE0);
    wait_end(d, f);
    err_idx = -1;
    @(negedge clk);
    chk("R9 fault", f, 1);
    chk("R9 no rf write", rf[0], 16'hA000);
    chk("R5 load dir", sv_dir, 1);
    sv_wr = 1; sv_wr_base = 24'hE0; sv_wr_count = 0; sv_wr_dir = 1; sv_wr_mv = 0;
    @(negedge clk);
    sv_wr = 0;
    pulse_resume();
    wait_end(d, f);
    @(negedge clk);
    chk("R7 load restart", rf[0], 16'h5070);
  endtask

  task automatic t_idle_write();
    logic [CNT_W-1:0] c0; logic [ADDR_W-1:0] b0;
    c0 = sv_count; b0 = sv_base;
    sv_wr = 1; sv_wr_base = 24'h123; sv_wr_count = 7; sv_wr_dir = 0; sv_wr_mv = 1;
    @(negedge clk);
    sv_wr = 0;
    @(negedge clk);
    chk("R8 idle count", sv_count, c0);
    chk("R8 idle base", sv_base, b0);
    chk("R8 idle mv", sv_mv, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_store();
    t_empty();
    t_continue();
    t_restart();
    t_edit_count();
    t_load();
    t_err_wins();
    t_idle_write();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule